// File: doc/BRIEF.md
# Quinary to Residue Converter

This block takes an unsigned six-digit base-5 number and produces its residues modulo 23, 24 and 25. These three moduli are 5^2−2, 5^2−1 and 5^2. They are pairwise coprime, so every value from 0 to 13799 has a unique residue triple. Each input digit is a 3-bit binary code with a legal value of 0 to 4. Each residue leaves the block as a pair of quinary digits.

The conversion runs in two levels. The six digits are split into two three-digit groups. Each group goes through a small converter that reduces the group value (0 to 124) modulo each of the moduli. A second level merges the group residues using the weight of the upper group, 125, taken modulo each modulus. Flags mark an input above the unique range and an input that carries an illegal digit code. The result can be registered once at the output or left combinational.

Top module: `qrns_conv`

## Requirements
- R1: `res23_o` holds (V mod 23), where V is the weighted value of the input. The residue value is never 23 or more.
- R2: `res24_o` holds (V mod 24). The residue value is never 24 or more.
- R3: `res25_o` holds (V mod 25). For legal input digits, this equals the two lowest input digits unchanged.
- R4: Each residue port is a quinary pair. Bits [5:3] carry the high digit d1 and bits [2:0] carry the low digit d0. Both digits are in 0..4, and the residue value is 5·d1+d0.
- R5: `out_of_range_o` is 1 exactly when V > 13799. The residues are still produced from V in that case, so 13799 gives 0 and 13800 gives 1.
- R6: `bad_digit_o` is 1 exactly when any digit code is 5, 6 or 7. V is then formed from the raw code values, and the residues and range flag follow from that V.
- R7: Input digit i sits in `digits_i[3i+2:3i]` with weight 5^i. V = 124 (digits 0,0,0,4,4,4) gives residues 9, 4 and 24, and V = 0 gives 0, 0 and 0.
- R8: With REG_OUT=1, every output shows the result for the input present at the previous rising clock edge and holds between edges. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| digits_i | input | 18 | Six quinary digit codes, digit 0 in the low bits |
| res23_o | output | 6 | Residue mod 23 as a quinary pair {d1,d0} |
| res24_o | output | 6 | Residue mod 24 as a quinary pair {d1,d0} |
| res25_o | output | 6 | Residue mod 25 as a quinary pair {d1,d0} |
| out_of_range_o | output | 1 | Input value exceeds 13799 |
| bad_digit_o | output | 1 | At least one digit code is above 4 |

## Verification
The bench drives every one of the 15625 legal inputs. This catches a wrong merge weight for the upper group, which would give wrong mod-23 or mod-24 residues for every value with a nonzero upper half. It also catches a missing final subtraction, which would leave residue values of 23 or 24 on the port.

The bench probes the range boundary at 13799 and 13800. A threshold that is off by one, or a comparison made only on the upper group, would move the flag to the wrong side of that boundary.

Inputs with illegal digit codes check two things. The bad-digit flag must rise. The residues must follow the raw code weights, so a design that clamps or drops the illegal codes would miscompare.

A latency probe samples the outputs after the input changes and before the next clock edge. An output stage that passes the input straight through would already show the new result there.

// File: rtl/qrns_pkg.sv
package qrns_pkg;
  localparam int BASE   = 5;
  localparam int EXP_N  = 2;
  localparam int NMOD   = 3;
  localparam int DIG_W  = 3;
  localparam int RES_W  = 5;
  localparam int PAIR_W = 2 * DIG_W;

  function automatic int pow_base(input int e);
    int p;
    p = 1;
    for (int i = 0; i < e; i++) p = p * BASE;
    return p;
  endfunction

  // moduli ordered 5^n-2, 5^n-1, 5^n
  function automatic int modulus(input int idx);
    return pow_base(EXP_N) - 2 + idx;
  endfunction

  localparam int TOP_LIMIT = modulus(0) * modulus(1) * modulus(2) - 1;
endpackage

// File: rtl/qrns_mod_reduce.sv
module qrns_mod_reduce #(
  parameter int IN_W   = 8,
  parameter int MOD    = 23,
  parameter int MAX_IN = 255,
  parameter int QUO_W  = ((MAX_IN / MOD) < 1) ? 1 : $clog2(MAX_IN / MOD + 1),
  parameter int REM_W  = $clog2(MOD)
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [REM_W-1:0] rem_o
);
  localparam int WW = IN_W + 1;

  logic [QUO_W:0][WW-1:0] stg;
  logic [QUO_W-1:0]       take;

  assign stg[QUO_W] = WW'(val_i);

  // restoring subtraction of MOD*2^k, high k first
  for (genvar k = QUO_W - 1; k >= 0; k--) begin : g_step
    localparam logic [WW-1:0] SUB = WW'(MOD) << k;
    assign take[k] = (stg[k+1] >= SUB);
    assign stg[k]  = take[k] ? (stg[k+1] - SUB) : stg[k+1];
  end

  assign rem_o = REM_W'(stg[0]);
endmodule

// File: rtl/qrns_group_conv.sv
module qrns_group_conv
  import qrns_pkg::*;
#(
  parameter int GRP = 3
) (
  input  logic [GRP*DIG_W-1:0]          digits_i,
  output logic [NMOD-1:0][RES_W-1:0]    res_o
);
  localparam int MAXG = ((1 << DIG_W) - 1) * (pow_base(GRP) - 1) / (BASE - 1);
  localparam int GV_W = $clog2(MAXG + 1);

  logic [GV_W-1:0] gval;

  always_comb begin
    gval = '0;
    for (int i = GRP - 1; i >= 0; i--)
      gval = gval * GV_W'(BASE) + GV_W'(digits_i[i*DIG_W +: DIG_W]);
  end

  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    localparam int MODV = modulus(m);
    logic [$clog2(MODV)-1:0] rem;
    qrns_mod_reduce #(
      .IN_W  (GV_W),
      .MOD   (MODV),
      .MAX_IN(MAXG)
    ) u_red (
      .val_i(gval),
      .rem_o(rem)
    );
    assign res_o[m] = RES_W'(rem);
  end
endmodule

// File: rtl/qrns_combine.sv
module qrns_combine
  import qrns_pkg::*;
#(
  parameter int GRP = 3
) (
  input  logic [NMOD-1:0][RES_W-1:0] hi_i,
  input  logic [NMOD-1:0][RES_W-1:0] lo_i,
  output logic [NMOD-1:0][RES_W-1:0] res_o
);
  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    localparam int MODV = modulus(m);
    localparam int WGT  = pow_base(GRP) % MODV;   // 10, 5, 0
    localparam int MAXS = WGT * (MODV - 1) + MODV - 1;
    localparam int SW   = $clog2(MAXS + 1) + 1;
    logic [SW-1:0]             sum;
    logic [$clog2(MODV)-1:0]   rem;

    assign sum = SW'(WGT) * SW'(hi_i[m]) + SW'(lo_i[m]);

    qrns_mod_reduce #(
      .IN_W  (SW),
      .MOD   (MODV),
      .MAX_IN(MAXS)
    ) u_red (
      .val_i(sum),
      .rem_o(rem)
    );
    assign res_o[m] = RES_W'(rem);
  end
endmodule

// File: rtl/qrns_conv.sv
module qrns_conv
  import qrns_pkg::*;
#(
  parameter int N_DIGITS = 6,
  parameter int GRP      = 3,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_DIGITS*DIG_W-1:0] digits_i,
  output logic [PAIR_W-1:0]         res23_o,
  output logic [PAIR_W-1:0]         res24_o,
  output logic [PAIR_W-1:0]         res25_o,
  output logic                      out_of_range_o,
  output logic                      bad_digit_o
);
  localparam int NG    = N_DIGITS / GRP;
  localparam int MAXV  = ((1 << DIG_W) - 1) * (pow_base(N_DIGITS) - 1) / (BASE - 1);
  localparam int VAL_W = $clog2(MAXV + 1);

  logic [NG-1:0][NMOD-1:0][RES_W-1:0] grp_res;
  logic [NG-1:0][NMOD-1:0][RES_W-1:0] acc;
  logic [NMOD-1:0][PAIR_W-1:0]        pair_d;
  logic [VAL_W-1:0]                   wval;
  logic                               oor_d, bad_d;

  // level 1: per-group residues
  for (genvar g = 0; g < NG; g++) begin : g_grp
    qrns_group_conv #(.GRP(GRP)) u_grp (
      .digits_i(digits_i[g*GRP*DIG_W +: GRP*DIG_W]),
      .res_o   (grp_res[g])
    );
  end

  // level 2: Horner merge from the top group down
  assign acc[NG-1] = grp_res[NG-1];
  for (genvar g = 0; g < NG - 1; g++) begin : g_merge
    qrns_combine #(.GRP(GRP)) u_comb (
      .hi_i (acc[g+1]),
      .lo_i (grp_res[g]),
      .res_o(acc[g])
    );
  end

  // residue to quinary digit pair
  for (genvar m = 0; m < NMOD; m++) begin : g_pair
    logic [DIG_W-1:0] d1;
    logic [RES_W-1:0] rest;
    always_comb begin
      d1 = '0;
      for (int k = 1; k < BASE; k++)
        if (acc[0][m] >= RES_W'(k * BASE)) d1 = DIG_W'(k);
      rest = acc[0][m] - RES_W'(d1) * RES_W'(BASE);
    end
    assign pair_d[m] = {d1, DIG_W'(rest)};
  end

  // full weighted value for the range flag
  always_comb begin
    wval  = '0;
    bad_d = 1'b0;
    for (int i = N_DIGITS - 1; i >= 0; i--) begin
      wval = wval * VAL_W'(BASE) + VAL_W'(digits_i[i*DIG_W +: DIG_W]);
      if (digits_i[i*DIG_W +: DIG_W] >= DIG_W'(BASE)) bad_d = 1'b1;
    end
  end
  assign oor_d = (wval > VAL_W'(TOP_LIMIT));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res23_o        <= '0;
        res24_o        <= '0;
        res25_o        <= '0;
        out_of_range_o <= 1'b0;
        bad_digit_o    <= 1'b0;
      end else begin
        res23_o        <= pair_d[0];
        res24_o        <= pair_d[1];
        res25_o        <= pair_d[2];
        out_of_range_o <= oor_d;
        bad_digit_o    <= bad_d;
      end
    end
  end else begin : g_comb
    assign res23_o        = pair_d[0];
    assign res24_o        = pair_d[1];
    assign res25_o        = pair_d[2];
    assign out_of_range_o = oor_d;
    assign bad_digit_o    = bad_d;
  end
endmodule

// File: rtl/qrns_conv_chk.sv
module qrns_conv_chk
  import qrns_pkg::*;
#(
  parameter int N_DIGITS = 6,
  parameter bit REG_OUT  = 1'b1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_DIGITS*DIG_W-1:0] digits_i,
  input logic [PAIR_W-1:0]         res23_o,
  input logic [PAIR_W-1:0]         res24_o,
  input logic [PAIR_W-1:0]         res25_o,
  input logic                      out_of_range_o,
  input logic                      bad_digit_o
);
  logic live;
  logic any_bad, low_legal, hi_zone;
  logic [4:0] v23, v24;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;
  end

  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < N_DIGITS; i++)
      if (digits_i[i*DIG_W +: DIG_W] > 3'd4) any_bad = 1'b1;
  end
  assign low_legal = (digits_i[2:0] <= 3'd4) && (digits_i[5:3] <= 3'd4);
  assign hi_zone   = (digits_i[N_DIGITS*DIG_W-1 -: DIG_W] == 3'd4) &&
                     (digits_i[N_DIGITS*DIG_W-DIG_W-1 -: DIG_W] >= 3'd3);
  assign v23 = 5'(res23_o[5:3]) * 5'd5 + 5'(res23_o[2:0]);
  assign v24 = 5'(res24_o[5:3]) * 5'd5 + 5'(res24_o[2:0]);

  AST_RES23_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) v23 < 5'd23); // R1
  AST_RES24_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) v24 < 5'd24); // R2
  AST_PAIR_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res23_o[5:3] <= 3'd4 && res23_o[2:0] <= 3'd4 && res24_o[5:3] <= 3'd4 &&
    res24_o[2:0] <= 3'd4 && res25_o[5:3] <= 3'd4 && res25_o[2:0] <= 3'd4); // R4

  if (REG_OUT) begin : g_seq
    AST_RES25_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live && $past(low_legal) |-> res25_o == $past(digits_i[5:0])); // R3
    AST_RANGE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live && $past(hi_zone) |-> out_of_range_o); // R5
    AST_BAD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live && $past(any_bad) |-> bad_digit_o); // R6
  end else begin : g_cmb
    AST_RES25_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_legal |-> res25_o == digits_i[5:0]); // R3
    AST_RANGE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_zone |-> out_of_range_o); // R5
    AST_BAD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_bad |-> bad_digit_o); // R6
  end
endmodule

bind qrns_conv qrns_conv_chk #(.N_DIGITS(N_DIGITS), .REG_OUT(REG_OUT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .digits_i      (digits_i),
  .res23_o       (res23_o),
  .res24_o       (res24_o),
  .res25_o       (res25_o),
  .out_of_range_o(out_of_range_o),
  .bad_digit_o   (bad_digit_o)
);

// File: tb/qrns_conv_tb.sv
`timescale 1ns/1ps
module qrns_conv_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] digits_i = '0;
  logic [5:0]  res23_o, res24_o, res25_o;
  logic        out_of_range_o, bad_digit_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  qrns_conv u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .digits_i      (digits_i),
    .res23_o       (res23_o),
    .res24_o       (res24_o),
    .res25_o       (res25_o),
    .out_of_range_o(out_of_range_o),
    .bad_digit_o   (bad_digit_o)
  );

  function automatic logic [17:0] enc(input int v);
    logic [17:0] d;
    int t;
    t = v;
    d = '0;
    for (int i = 0; i < 6; i++) begin
      d[i*3 +: 3] = 3'(t % 5);
      t = t / 5;
    end
    return d;
  endfunction

  function automatic logic [5:0] pr(input int r);
    return {3'(r / 5), 3'(r % 5)};
  endfunction

  function automatic logic [19:0] expect_of(input logic [17:0] d);
    int v;
    logic bad;
    v = 0;
    bad = 1'b0;
    for (int i = 5; i >= 0; i--) begin
      v = v * 5 + int'(d[i*3 +: 3]);
      if (d[i*3 +: 3] > 3'd4) bad = 1'b1;
    end
    return {pr(v % 23), pr(v % 24), pr(v % 25), v > 13799, bad};
  endfunction

  task automatic compare(input logic [19:0] exp_v, input string tag);
    logic [19:0] act;
    act = {res23_o, res24_o, res25_o, out_of_range_o, bad_digit_o};
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp_v);
    end
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic apply(input logic [17:0] d, input string tag);
    digits_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    compare(expect_of(d), tag);
  endtask

  task automatic t_reset;
    digits_i = enc(124);
    repeat (3) @(negedge clk_i);
    compare(20'h0, "R8 reset clears outputs");
    rst_ni = 1'b1;
  endtask

  task automatic t_known;
    apply(enc(124), "R7/R1/R2/R3 value 124");
    compare({6'o14, 6'o04, 6'o44, 1'b0, 1'b0}, "R7 value 124 literal");
    apply(enc(0), "R7 value 0");
    compare(20'h0, "R7 value 0 literal");
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 15625; v++) apply(enc(v), "R1/R2/R3/R4/R5 sweep");
  endtask

  task automatic t_range;
    apply(enc(13799), "R5 top of range");
    compare({pr(13799 % 23), pr(13799 % 24), pr(13799 % 25), 1'b0, 1'b0}, "R5 13799 flag low");
    apply(enc(13800), "R5 first out of range");
    compare({pr(0), pr(0), pr(0), 1'b1, 1'b0}, "R5 13800 flag high");
    apply(enc(15624), "R5 maximum legal input");
  endtask

  task automatic t_bad_digits;
    apply(18'o777777, "R6 all codes 7");
    apply(18'o000005, "R6 code 5 in digit 0");
    apply(18'o600000, "R6 code 6 in digit 5");
    apply(18'o040700, "R6 code 7 mid digit");
  endtask

  task automatic t_latency;
    apply(enc(100), "R8 setup");
    digits_i = enc(7777);
    #1;
    compare(expect_of(enc(100)), "R8 holds before edge");
    @(posedge clk_i);
    @(negedge clk_i);
    compare(expect_of(enc(7777)), "R8 updates after edge");
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk_i);
    t_known();
    t_range();
    t_bad_digits();
    t_latency();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule